// File: doc/BRIEF.md
# Command-Triggered Memory Controller Front End

This block sits between a small byte-wide register bus and a non-volatile memory array. Software loads a command code, a target address and a data byte into registers, then starts the operation in one of three ways: by setting an execute bit in a control register, by reading the memory window, or by writing to it. Each command code is tied to exactly one of these trigger kinds. A trigger of any other kind does nothing.

While an operation runs, a busy flag is raised and the operand registers are frozen. A trigger that arrives during that time is dropped. Writes and erases are protected. They only start inside a short window that opens when a key byte is written to a key register. Every array access is checked against lock bits for the region it targets. The requesting path (external programmer or self-programming) picks which of two independent lock sets applies. The array itself is a behavioural stub that finishes after a fixed number of cycles.

The controller is a three-state machine: `S_IDLE` waits for an accepted trigger, `S_RUN` counts the latency, and `S_DONE` commits the array write or captures the read byte. The transitions are `S_IDLE -> S_RUN` on an accepted trigger, `S_RUN -> S_DONE` when the latency counter reaches `LAT-1`, and `S_DONE -> S_IDLE` unconditionally.

Top module: `memctl_front`

## Requirements
- R1: After reset, every readable register (offsets 0 to 6) reads 0 and `busy` is 0.
- R2: With command 0x01 (read) loaded, a `mem_re` pulse starts an operation. `busy` is high for exactly LAT+1 cycles, after which the data register (offset 2) holds the array byte at the address in offsets 0 (low byte) and 1 (high bits).
- R3: With command 0x02 (write) loaded and the key window open, a `mem_we` pulse starts an operation that stores the `mem_wdata` byte at the loaded address when `busy` falls.
- R4: Writing 1 to bit 0 of control register A (offset 4) starts an action command. Command 0x03 sets the addressed byte to 0xFF and needs the key. Command 0x04 is a check run that touches neither the array nor the data register. Bit 0 reads 1 in the cycle after the write and 0 in the cycle after that.
- R5: A trigger whose kind does not match the loaded command is ignored: `busy` stays low.
- R6: While `busy` is high, writes to offsets 0 to 5 (address low, address high, data, command, control A, control B) are ignored.
- R7: A trigger that arrives while `busy` is high is ignored. It neither lengthens the busy period nor queues a second operation.
- R8: Writing 0x9D to the key register (offset 7) opens a window of 4 cycles. A protected trigger (commands 0x02, 0x03) is accepted only inside this window. Outside it, or after a wrong key, the trigger is dropped without setting `busy` or the error flag.
- R9: Lock bits, when set to 1, block access. Bit positions are [0] app read, [1] app write, [2] table read, [3] table write, [4] boot read, [5] boot write. The app region is below 0x300, the table region runs from 0x300 to 0x37F, and the boot region starts at 0x380. `prog_ext`=1 selects `lock_ext`, and 0 selects `lock_self`. A blocked trigger is dropped, `busy` stays low, and status bit 0 (offset 6) becomes 1 and stays 1.
- R10: Command 0x00, and any code above 0x04, starts nothing on any trigger kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on reg_addr) |
| mem_re | input | 1 | Memory window read strobe (read trigger) |
| mem_we | input | 1 | Memory window write strobe (write trigger) |
| mem_wdata | input | 8 | Byte written through the memory window |
| prog_ext | input | 1 | 1 = external programming path, 0 = self-programming |
| lock_ext | input | 6 | Region lock bits for the external path |
| lock_self | input | 6 | Region lock bits for the self-programming path |
| busy | output | 1 | Operation in progress (also status bit 7) |

## Verification
A latency counter in the wrong state shows up at once as a busy period that is not LAT+1 cycles long, and it is measured on every started operation. A decode, key-window or lock fault shows up in the first cycle after the trigger, either as `busy` being high when it should be low or the reverse, or as the error bit appearing. A fault in register freezing or in array commit stays hidden until the operation ends. It then shows up when the registers are read back, or when a following read command returns the wrong byte, a few cycles later.

// File: rtl/memctl_pkg.sv
package memctl_pkg;

    localparam logic [7:0] CMD_NOP   = 8'h00;
    localparam logic [7:0] CMD_READ  = 8'h01;
    localparam logic [7:0] CMD_WRITE = 8'h02;
    localparam logic [7:0] CMD_ERASE = 8'h03;
    localparam logic [7:0] CMD_CHECK = 8'h04;

    localparam logic [2:0] REG_ADDR_LO = 3'd0;
    localparam logic [2:0] REG_ADDR_HI = 3'd1;
    localparam logic [2:0] REG_DATA    = 3'd2;
    localparam logic [2:0] REG_CMD     = 3'd3;
    localparam logic [2:0] REG_CTRLA   = 3'd4;
    localparam logic [2:0] REG_CTRLB   = 3'd5;
    localparam logic [2:0] REG_STATUS  = 3'd6;
    localparam logic [2:0] REG_KEY     = 3'd7;

    typedef enum logic [1:0] {S_IDLE, S_RUN, S_DONE} state_e;
    typedef enum logic [1:0] {TRG_NONE, TRG_EXEC, TRG_READ, TRG_WRITE} trig_e;
    typedef enum logic [1:0] {RGN_APP = 2'd0, RGN_TBL = 2'd1, RGN_BOOT = 2'd2} region_e;

    typedef struct packed {
        trig_e kind;      // which trigger starts the command
        logic  prot;      // needs the key window
        logic  wr_acc;    // modifies the array
        logic  arr_acc;   // touches the array (lock checked)
        logic  rd_res;    // captures array byte into data register
        logic  valid;     // a defined command
    } cmd_info_t;

    function automatic cmd_info_t decode_cmd(input logic [7:0] code);
        cmd_info_t d;
        d.kind    = TRG_NONE;
        d.prot    = 1'b0;
        d.wr_acc  = 1'b0;
        d.arr_acc = 1'b0;
        d.rd_res  = 1'b0;
        d.valid   = 1'b0;
        unique case (code)
            CMD_READ: begin
                d.kind = TRG_READ; d.arr_acc = 1'b1; d.rd_res = 1'b1; d.valid = 1'b1;
            end
            CMD_WRITE: begin
                d.kind = TRG_WRITE; d.prot = 1'b1; d.wr_acc = 1'b1; d.arr_acc = 1'b1; d.valid = 1'b1;
            end
            CMD_ERASE: begin
                d.kind = TRG_EXEC; d.prot = 1'b1; d.wr_acc = 1'b1; d.arr_acc = 1'b1; d.valid = 1'b1;
            end
            CMD_CHECK: begin
                d.kind = TRG_EXEC; d.valid = 1'b1;
            end
            default: d.valid = 1'b0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/memctl_keywin.sv
module memctl_keywin #(
    parameter logic [7:0] KEY = 8'h9D,
    parameter int         WIN = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_we,
    input  logic [7:0] key_val,
    input  logic       consume,
    output logic       open
);
    localparam int CW = $clog2(WIN + 1);

    logic [CW-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (key_we && key_val == KEY) begin
            left_q <= CW'(WIN);
        end else if (consume) begin
            left_q <= '0;
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign open = (left_q != '0);
endmodule

// File: rtl/memctl_lockchk.sv
module memctl_lockchk
    import memctl_pkg::*;
#(
    parameter int               ADDR_W    = 10,
    parameter logic [ADDR_W-1:0] TBL_BASE  = 10'h300,
    parameter logic [ADDR_W-1:0] BOOT_BASE = 10'h380
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              is_write,
    input  logic              path_ext,
    input  logic [5:0]        lock_ext,
    input  logic [5:0]        lock_self,
    output logic              blocked
);
    region_e    rgn;
    logic [5:0] lock_sel;
    logic [2:0] idx;

    always_comb begin
        if (addr >= BOOT_BASE)     rgn = RGN_BOOT;
        else if (addr >= TBL_BASE) rgn = RGN_TBL;
        else                       rgn = RGN_APP;
        lock_sel = path_ext ? lock_ext : lock_self;
        idx      = {rgn, is_write};
        blocked  = lock_sel[idx];
    end
endmodule

// File: rtl/memctl_array.sv
module memctl_array #(
    parameter int ADDR_W = 10,
    parameter int DW     = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[addr] <= wdata;
    end

    assign rdata = cells[addr];
endmodule

// File: rtl/memctl_front.sv
module memctl_front
    import memctl_pkg::*;
#(
    parameter int               ADDR_W    = 10,
    parameter int               LAT       = 6,
    parameter int               KEY_WIN   = 4,
    parameter logic [7:0]       KEY_VAL   = 8'h9D,
    parameter logic [ADDR_W-1:0] TBL_BASE  = 10'h300,
    parameter logic [ADDR_W-1:0] BOOT_BASE = 10'h380
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_we,
    input  logic [2:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       mem_re,
    input  logic       mem_we,
    input  logic [7:0] mem_wdata,
    input  logic       prog_ext,
    input  logic [5:0] lock_ext,
    input  logic [5:0] lock_self,
    output logic       busy
);
    localparam int HI_W = ADDR_W - 8;
    localparam int CW   = $clog2(LAT + 1);

    state_e          state_q, state_d;
    logic [CW-1:0]   cnt_q;
    logic [7:0]      addr_lo_q;
    logic [HI_W-1:0] addr_hi_q;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]      data_q;
    logic [7:0]      cmd_q;
    logic [7:0]      ctrlb_q;
    logic            exec_q;
    logic            err_q;
    logic [7:0]      wbuf_q;

    cmd_info_t info;
    logic      wr_ok, exec_trig, rd_trig, wr_trig;
    logic      fired, key_ok, lock_blk, start, lock_err, consume;
    logic      win_open, blk_raw;
    logic      arr_we, cap_rd, cnt_last;
    logic [7:0] arr_rdata;

    assign addr_q = {addr_hi_q, addr_lo_q};
    assign info   = decode_cmd(cmd_q);

    // trigger qualification
    always_comb begin
        wr_ok     = reg_we && (state_q == S_IDLE);
        exec_trig = wr_ok && (reg_addr == REG_CTRLA) && reg_wdata[0];
        rd_trig   = mem_re && (state_q == S_IDLE);
        wr_trig   = mem_we && (state_q == S_IDLE);
        fired     = info.valid &&
                    (((info.kind == TRG_EXEC)  && exec_trig) ||
                     ((info.kind == TRG_READ)  && rd_trig)   ||
                     ((info.kind == TRG_WRITE) && wr_trig));
        key_ok    = !info.prot || win_open;
        lock_blk  = info.arr_acc && blk_raw;
        start     = fired && key_ok && !lock_blk;
        lock_err  = fired && key_ok && lock_blk;
        consume   = fired && key_ok && info.prot;
    end

    memctl_keywin #(.KEY(KEY_VAL), .WIN(KEY_WIN)) u_keywin (
        .clk     (clk),
        .rst_n   (rst_n),
        .key_we  (reg_we && (reg_addr == REG_KEY)),
        .key_val (reg_wdata),
        .consume (consume),
        .open    (win_open)
    );

    memctl_lockchk #(.ADDR_W(ADDR_W), .TBL_BASE(TBL_BASE), .BOOT_BASE(BOOT_BASE)) u_lock (
        .addr      (addr_q),
        .is_write  (info.wr_acc),
        .path_ext  (prog_ext),
        .lock_ext  (lock_ext),
        .lock_self (lock_self),
        .blocked   (blk_raw)
    );

    memctl_array #(.ADDR_W(ADDR_W), .DW(8)) u_array (
        .clk   (clk),
        .we    (arr_we),
        .addr  (addr_q),
        .wdata (wbuf_q),
        .rdata (arr_rdata)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    assign cnt_last = (cnt_q == CW'(LAT - 1));

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (start)    state_d = S_RUN;
            S_RUN:  if (cnt_last) state_d = S_DONE;
            S_DONE:               state_d = S_IDLE;
            default:              state_d = S_IDLE;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        busy   = (state_q != S_IDLE);
        arr_we = (state_q == S_DONE) && info.wr_acc;
        cap_rd = (state_q == S_DONE) && info.rd_res;
    end

    // latency counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                cnt_q <= '0;
        else if (state_q == S_RUN) cnt_q <= cnt_q + 1'b1;
        else                       cnt_q <= '0;
    end

    // operand and control registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_lo_q <= '0;
            addr_hi_q <= '0;
            data_q    <= '0;
            cmd_q     <= '0;
            ctrlb_q   <= '0;
            exec_q    <= 1'b0;
            err_q     <= 1'b0;
            wbuf_q    <= '0;
        end else begin
            exec_q <= exec_trig;
            if (lock_err) err_q <= 1'b1;
            if (wr_ok) begin
                unique case (reg_addr)
                    REG_ADDR_LO: addr_lo_q <= reg_wdata;
                    REG_ADDR_HI: addr_hi_q <= reg_wdata[HI_W-1:0];
                    REG_DATA:    data_q    <= reg_wdata;
                    REG_CMD:     cmd_q     <= reg_wdata;
                    REG_CTRLB:   ctrlb_q   <= reg_wdata;
                    default:     ;
                endcase
            end
            if (start) wbuf_q <= (info.kind == TRG_WRITE) ? mem_wdata : 8'hFF;
            if (cap_rd) data_q <= arr_rdata;
        end
    end

    // register read mux
    always_comb begin
        unique case (reg_addr)
            REG_ADDR_LO: reg_rdata = addr_lo_q;
            REG_ADDR_HI: reg_rdata = 8'(addr_hi_q);
            REG_DATA:    reg_rdata = data_q;
            REG_CMD:     reg_rdata = cmd_q;
            REG_CTRLA:   reg_rdata = {7'b0, exec_q};
            REG_CTRLB:   reg_rdata = ctrlb_q;
            REG_STATUS:  reg_rdata = {busy, 6'b0, err_q};
            default:     reg_rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/memctl_front_chk.sv
module memctl_front_chk #(
    parameter int ADDR_W = 10,
    parameter int LAT    = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic [7:0]        cmd_q,
    input logic [ADDR_W-1:0] addr_q,
    input logic              exec_q,
    input logic              err_q,
    input logic              reg_we,
    input logic [2:0]        reg_addr
);
    logic [15:0] run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     run_len <= '0;
        else if (busy && run_len != '1) run_len <= run_len + 1'b1;
        else if (!busy)                 run_len <= '0;
    end

    AST_BUSY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_len <= 16'(LAT))); // R2

    AST_CMD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(cmd_q)); // R6

    AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(addr_q)); // R6

    AST_NOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == 8'h00 && !busy) |=> !busy); // R10

    AST_LOCK_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_q) |-> !busy); // R9

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q); // R9

    AST_EXEC_SELFCLR: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_q && !(reg_we && reg_addr == 3'd4)) |=> !exec_q); // R4
endmodule

bind memctl_front memctl_front_chk #(.ADDR_W(ADDR_W), .LAT(LAT)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .cmd_q    (cmd_q),
    .addr_q   (addr_q),
    .exec_q   (exec_q),
    .err_q    (err_q),
    .reg_we   (reg_we),
    .reg_addr (reg_addr)
);

// File: tb/memctl_front_test.sv
module memctl_front_test;
    localparam int LAT = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       mem_re = 1'b0;
    logic       mem_we = 1'b0;
    logic [7:0] mem_wdata = 8'd0;
    logic       prog_ext = 1'b0;
    logic [5:0] lock_ext = 6'd0;
    logic [5:0] lock_self = 6'd0;
    logic       busy;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    memctl_front #(.LAT(LAT)) uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_re(mem_re),
        .mem_we(mem_we), .mem_wdata(mem_wdata), .prog_ext(prog_ext),
        .lock_ext(lock_ext), .lock_self(lock_self), .busy(busy)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse_re();
        mem_re = 1'b1;
        @(negedge clk);
        mem_re = 1'b0;
    endtask

    task automatic pulse_we(input logic [7:0] d);
        mem_we = 1'b1; mem_wdata = d;
        @(negedge clk);
        mem_we = 1'b0;
    endtask

    task automatic set_addr(input logic [9:0] a);
        wr(3'd0, a[7:0]);
        wr(3'd1, {6'd0, a[9:8]});
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy && n < 100) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic do_write(input logic [9:0] a, input logic [7:0] d, input string req);
        int n;
        set_addr(a);
        wr(3'd3, 8'h02);
        wr(3'd7, 8'h9D);
        pulse_we(d);
        chk(req, busy, 1);
        wait_idle(n);
        chk(req, n, LAT + 1);
    endtask

    task automatic do_read(input logic [9:0] a, output logic [7:0] d, input string req);
        int n;
        set_addr(a);
        wr(3'd3, 8'h01);
        pulse_re();
        chk(req, busy, 1);
        wait_idle(n);
        chk(req, n, LAT + 1);
        rd(3'd2, d);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        for (int i = 0; i < 7; i++) begin
            rd(3'(i), v);
            chk("R1 reg", v, 0);
        end
        chk("R1 busy", busy, 0);
    endtask

    task automatic t_nop();
        wr(3'd3, 8'h00);
        wr(3'd4, 8'h01);
        chk("R10 exec nop", busy, 0);
        pulse_re();
        chk("R10 re nop", busy, 0);
        wr(3'd7, 8'h9D);
        pulse_we(8'h33);
        chk("R10 we nop", busy, 0);
        wr(3'd3, 8'h07);
        wr(3'd4, 8'h01);
        chk("R10 code 7 exec", busy, 0);
        pulse_re();
        chk("R10 code 7 re", busy, 0);
    endtask

    task automatic t_write_read();
        logic [7:0] v;
        do_write(10'h012, 8'h5A, "R3 write app");
        do_read(10'h012, v, "R2 read app");
        chk("R2 data app", v, 8'h5A);
        do_write(10'h345, 8'hC3, "R3 write tbl");
        do_read(10'h345, v, "R2 read tbl");
        chk("R2 data tbl", v, 8'hC3);
        do_read(10'h012, v, "R2 reread");
        chk("R3 no clobber", v, 8'h5A);
    endtask

    task automatic t_action();
        logic [7:0] v;
        int n;
        set_addr(10'h012);
        wr(3'd3, 8'h03);
        wr(3'd7, 8'h9D);
        wr(3'd4, 8'h01);
        rd(3'd4, v);
        chk("R4 exec bit set", v, 1);
        chk("R4 erase busy", busy, 1);
        @(negedge clk);
        rd(3'd4, v);
        chk("R4 exec bit clear", v, 0);
        wait_idle(n);
        chk("R4 erase len", n, LAT);
        do_read(10'h012, v, "R4 read erased");
        chk("R4 erased", v, 8'hFF);
        wr(3'd2, 8'h21);
        wr(3'd3, 8'h04);
        wr(3'd4, 8'h01);
        chk("R4 check busy", busy, 1);
        wait_idle(n);
        chk("R4 check len", n, LAT + 1);
        rd(3'd2, v);
        chk("R4 check data kept", v, 8'h21);
    endtask

    task automatic t_mismatch();
        wr(3'd3, 8'h01);
        wr(3'd4, 8'h01);
        chk("R5 exec on read cmd", busy, 0);
        pulse_we(8'h11);
        chk("R5 we on read cmd", busy, 0);
        wr(3'd3, 8'h02);
        wr(3'd7, 8'h9D);
        pulse_re();
        chk("R5 re on write cmd", busy, 0);
        wr(3'd3, 8'h04);
        pulse_re();
        chk("R5 re on check cmd", busy, 0);
    endtask

    task automatic t_freeze();
        logic [7:0] v;
        int n;
        set_addr(10'h012);
        wr(3'd2, 8'h11);
        wr(3'd5, 8'h22);
        wr(3'd3, 8'h04);
        wr(3'd4, 8'h01);
        chk("R6 busy", busy, 1);
        wr(3'd0, 8'h55);
        wr(3'd1, 8'h03);
        wr(3'd2, 8'h77);
        wr(3'd3, 8'h02);
        wr(3'd5, 8'hAA);
        wait_idle(n);
        rd(3'd0, v); chk("R6 addr lo", v, 8'h12);
        rd(3'd1, v); chk("R6 addr hi", v, 8'h00);
        rd(3'd2, v); chk("R6 data", v, 8'h11);
        rd(3'd3, v); chk("R6 cmd", v, 8'h04);
        rd(3'd5, v); chk("R6 ctrlb", v, 8'h22);
    endtask

    task automatic t_busy_trig();
        int n;
        set_addr(10'h012);
        wr(3'd3, 8'h01);
        pulse_re();
        pulse_re();
        wait_idle(n);
        chk("R7 len", n, LAT);
        @(negedge clk);
        chk("R7 no second op", busy, 0);
        @(negedge clk);
        chk("R7 still idle", busy, 0);
    endtask

    task automatic t_key();
        logic [7:0] v;
        int n;
        set_addr(10'h020);
        wr(3'd3, 8'h02);
        pulse_we(8'hE1);
        chk("R8 no key", busy, 0);
        wr(3'd7, 8'h9C);
        pulse_we(8'hE2);
        chk("R8 wrong key", busy, 0);
        wr(3'd7, 8'h9D);
        repeat (4) @(negedge clk);
        pulse_we(8'hE3);
        chk("R8 window closed", busy, 0);
        rd(3'd6, v);
        chk("R8 no error", v, 0);
        wr(3'd7, 8'h9D);
        repeat (3) @(negedge clk);
        pulse_we(8'hE4);
        chk("R8 last window cycle", busy, 1);
        wait_idle(n);
        do_read(10'h020, v, "R8 read");
        chk("R8 data", v, 8'hE4);
    endtask

    task automatic t_lock();
        logic [7:0] v;
        prog_ext = 1'b0;
        lock_self = 6'b000010;
        set_addr(10'h012);
        wr(3'd3, 8'h02);
        wr(3'd7, 8'h9D);
        pulse_we(8'h99);
        chk("R9 self app write blocked", busy, 0);
        rd(3'd6, v);
        chk("R9 err set", v, 8'h01);
        prog_ext = 1'b1;
        do_read(10'h012, v, "R9 read other path");
        chk("R9 array unchanged", v, 8'hFF);
        do_write(10'h012, 8'h99, "R9 ext path write");
        do_read(10'h012, v, "R9 readback");
        chk("R9 ext write landed", v, 8'h99);
        lock_ext = 6'b010000;
        set_addr(10'h3A0);
        wr(3'd3, 8'h01);
        pulse_re();
        chk("R9 boot read blocked", busy, 0);
        rd(3'd2, v);
        chk("R9 data kept", v, 8'h99);
        rd(3'd6, v);
        chk("R9 err sticky", v, 8'h01);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_nop();
        t_write_read();
        t_action();
        t_mismatch();
        t_freeze();
        t_busy_trig();
        t_key();
        t_lock();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule